// File: doc/BRIEF.md
# Multi-Plan Clock Enable Generator

This block turns one fast master clock into a family of single-cycle enable strobes. Each strobe stands in for a slower derived clock: one for the processor, one at twice the processor rate for a debug port, one for the compute engine, and one shared by the converter and its filter. A prescaler sets the base tick rate from a two-bit frequency plan. A power-of-two divider then produces the processor and debug strobes from that base tick. Logic downstream clocks on the master clock and qualifies its registers with these strobes. No real divided clocks are made.

Two power states override the settings. Sleep forces the plan back to the default. Brownout thins every strobe to seven eighths of its nominal rate. All plan and divider changes are held until the running counter reaches its terminal count, so a strobe period is never cut short.

Top module: `mclk_enable_gen`

## Requirements
- R1: `cpu_en` fires once every 2^(D+2) prescaler ticks, where D is the latched `cpu_div` value. A value of 7 behaves as 6.
- R2: During and after reset, the plan is the default one (prescaler period 4) and the latched divider is 0, whatever `mode_sel` holds. All enables are low during reset, and the first `adc_en` comes on the 4th rising edge after reset is released.
- R3: `mode_sel` encoding: 2'b00 is the default plan (prescaler period 4 master cycles); 2'b01 is the intermediate plan (period 3, so `adc_en`, `ce_en`, `cpu_en` and `dbg_en` all speed up by one third); 2'b10 is the high plan (period 4); 2'b11 acts as 2'b00. `adc_en` fires on every prescaler tick.
- R4: In the high plan with `ce_fast` set, `ce_en` fires every 2 master cycles while `adc_en` stays at every 4. In every other case, `ce_en` matches the `adc_en` rate.
- R5: `dbg_en` fires twice per processor period: at the halfway tick and at the terminal tick. While `dbg_off` is high, `dbg_en` is low in the following cycle. `cpu_en` is not affected by `dbg_off`.
- R6: When `sleep` is high, the plan latched at a prescaler terminal count is the default plan, regardless of `mode_sel`.
- R7: While `brownout` is high, each output drops every eighth pulse it would have produced, counted from the start of the brownout. The count restarts when `brownout` falls.
- R8: `mode_sel`, `sleep` and `ce_fast` are sampled only at a prescaler terminal count. `cpu_div` is sampled only at a processor terminal count.
- R9: Every enable is registered: it rises one cycle after its internal trigger and is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Frequency plan select (bit 1 high plan, bit 0 intermediate plan) |
| ce_fast | input | 1 | Doubles the compute-engine rate in the high plan |
| cpu_div | input | 3 | Processor divide select D |
| dbg_off | input | 1 | Suppresses the debug enable |
| sleep | input | 1 | Sleep state; forces the default plan |
| brownout | input | 1 | Brownout state; thins the enables to 7/8 |
| cpu_en | output | 1 | Processor clock enable |
| dbg_en | output | 1 | Debug enable at twice the processor rate |
| ce_en | output | 1 | Compute-engine clock enable |
| adc_en | output | 1 | Converter and filter clock enable |

## Verification
The hardest case to reach from the ports is a settings change that lands in the middle of a running period. The old period must finish in full before the new one starts. The bench waits for a strobe and changes the divider or plan on the very next cycle. It then measures the next two gaps: the first must still show the old period and the second the new one. Brownout thinning is checked over windows that span a whole number of eight-pulse groups, so the expected counts do not depend on phase. A per-cycle reference model also follows every edge.

// File: rtl/mceg_pkg.sv
package mceg_pkg;

  typedef enum logic [1:0] {
    PLAN_BASE = 2'd0,
    PLAN_MID  = 2'd1,
    PLAN_FAST = 2'd2
  } plan_e;

  // Power state wins over the plan field; the reserved code maps to base.
  function automatic plan_e pick_plan(input logic [1:0] mode, input logic sleep);
    if (sleep) return PLAN_BASE;
    case (mode)
      2'b01:   return PLAN_MID;
      2'b10:   return PLAN_FAST;
      default: return PLAN_BASE;
    endcase
  endfunction

  function automatic int unsigned plan_period(input plan_e p,
                                              input int unsigned base_per,
                                              input int unsigned mid_per);
    return (p == PLAN_MID) ? mid_per : base_per;
  endfunction

  // Processor span in prescaler ticks: 2^(min(div,max)+2).
  function automatic int unsigned cpu_span(input int unsigned div,
                                           input int unsigned max_div);
    int unsigned d;
    d = (div > max_div) ? max_div : div;
    return 32'd1 << (d + 2);
  endfunction

endpackage

// File: rtl/mceg_prescale.sv
module mceg_prescale
  import mceg_pkg::*;
#(
  parameter int unsigned PER_BASE = 4,
  parameter int unsigned PER_MID  = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       sleep_i,
  input  logic       ce_fast_i,
  output logic       base_tick,
  output logic       ce_cand,
  output plan_e      plan_q
);
  localparam int unsigned PER_MAX = (PER_BASE > PER_MID) ? PER_BASE : PER_MID;
  localparam int CW = (PER_MAX > 2) ? $clog2(PER_MAX) : 1;

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last_idx;
  logic [CW-1:0] half_idx;
  logic          fast_q;

  always_comb begin
    last_idx = CW'(plan_period(plan_q, PER_BASE, PER_MID) - 1);
    half_idx = CW'(PER_BASE / 2 - 1);
  end

  assign base_tick = (cnt_q == last_idx);
  assign ce_cand   = base_tick | ((plan_q == PLAN_FAST) && fast_q && (cnt_q == half_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      plan_q <= PLAN_BASE;
      fast_q <= 1'b0;
    end else if (base_tick) begin
      cnt_q  <= '0;
      plan_q <= pick_plan(mode_i, sleep_i);
      fast_q <= ce_fast_i;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R8: the plan only moves at a terminal count
  p_plan_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !base_tick |=> $stable(plan_q));

  // R6: sleep at the terminal count yields the base plan
  p_sleep_base_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (base_tick && sleep_i) |=> (plan_q == PLAN_BASE));

endmodule

// File: rtl/mceg_cpudiv.sv
module mceg_cpudiv
  import mceg_pkg::*;
#(
  parameter int DIVW    = 3,
  parameter int MAX_DIV = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            base_tick,
  input  logic [DIVW-1:0] div_i,
  output logic            cpu_cand,
  output logic            dbg_cand_raw
);
  localparam int CCW = MAX_DIV + 2;

  logic [CCW-1:0]  cnt_q;
  logic [CCW-1:0]  last_idx;
  logic [CCW-1:0]  mid_idx;
  logic [DIVW-1:0] div_q;

  always_comb begin
    last_idx = CCW'(cpu_span(32'(div_q), MAX_DIV) - 1);
    mid_idx  = CCW'(cpu_span(32'(div_q), MAX_DIV) / 2 - 1);
  end

  assign cpu_cand     = base_tick && (cnt_q == last_idx);
  assign dbg_cand_raw = base_tick && ((cnt_q == last_idx) || (cnt_q == mid_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= '0;
    end else if (base_tick) begin
      if (cnt_q == last_idx) begin
        cnt_q <= '0;
        div_q <= div_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R8: the divide select only moves at a processor terminal count
  p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_cand |=> $stable(div_q));

  // R1: processor strobes sit on prescaler ticks
  p_cpu_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_cand |-> base_tick);

endmodule

// File: rtl/mceg_thin.sv
module mceg_thin #(
  parameter int unsigned DROP_N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic brown_i,
  input  logic cand_i,
  output logic pulse_o
);
  localparam int BW = $clog2(DROP_N);

  logic [BW-1:0] seen_q;
  logic          drop;

  assign drop = brown_i && cand_i && (seen_q == BW'(DROP_N - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q  <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= cand_i && !drop;
      if (!brown_i)    seen_q <= '0;
      else if (cand_i) seen_q <= drop ? '0 : seen_q + 1'b1;
    end
  end

  // R9: single-cycle strobes
  p_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R9: outside brownout every trigger reaches the output one cycle later
  p_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_i && !brown_i) |=> pulse_o);

  // R7: the eighth trigger inside brownout is swallowed
  p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> !pulse_o);

endmodule

// File: rtl/mclk_enable_gen.sv
module mclk_enable_gen
  import mceg_pkg::*;
#(
  parameter int unsigned PER_BASE = 4,
  parameter int unsigned PER_MID  = 3,
  parameter int          DIVW     = 3,
  parameter int          MAX_DIV  = 6,
  parameter int unsigned DROP_N   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode_sel,
  input  logic            ce_fast,
  input  logic [DIVW-1:0] cpu_div,
  input  logic            dbg_off,
  input  logic            sleep,
  input  logic            brownout,
  output logic            cpu_en,
  output logic            dbg_en,
  output logic            ce_en,
  output logic            adc_en
);
  localparam int N_OUT = 4;

  logic       base_tick;
  logic       ce_cand;
  logic       cpu_cand;
  logic       dbg_cand_raw;
  logic       dbg_cand;
  plan_e      plan_q;
  logic [N_OUT-1:0] cand;
  logic [N_OUT-1:0] pulse;

  mceg_prescale #(.PER_BASE(PER_BASE), .PER_MID(PER_MID)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_sel),
    .sleep_i   (sleep),
    .ce_fast_i (ce_fast),
    .base_tick (base_tick),
    .ce_cand   (ce_cand),
    .plan_q    (plan_q)
  );

  mceg_cpudiv #(.DIVW(DIVW), .MAX_DIV(MAX_DIV)) u_div (
    .clk          (clk),
    .rst_n        (rst_n),
    .base_tick    (base_tick),
    .div_i        (cpu_div),
    .cpu_cand     (cpu_cand),
    .dbg_cand_raw (dbg_cand_raw)
  );

  assign dbg_cand = dbg_cand_raw && !dbg_off;
  assign cand     = {dbg_cand, cpu_cand, ce_cand, base_tick};

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    mceg_thin #(.DROP_N(DROP_N)) u_thin (
      .clk     (clk),
      .rst_n   (rst_n),
      .brown_i (brownout),
      .cand_i  (cand[g]),
      .pulse_o (pulse[g])
    );
  end

  assign adc_en = pulse[0];
  assign ce_en  = pulse[1];
  assign cpu_en = pulse[2];
  assign dbg_en = pulse[3];

  // R5: debug strobe is silenced the cycle after the disable is seen
  p_dbg_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_off |=> !dbg_en);

  // R3: the converter strobe always follows a prescaler tick
  p_adc_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
    adc_en |-> $past(base_tick));

endmodule

// File: tb/mclk_enable_gen_bench.sv
module mclk_enable_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] mode_sel;
  logic       ce_fast, dbg_off, sleep, brownout;
  logic [2:0] cpu_div;
  logic       cpu_en, dbg_en, ce_en, adc_en;
  logic [3:0] outs;

  always #2 clk = ~clk;

  mclk_enable_gen u_mclk_enable_gen (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ce_fast(ce_fast),
    .cpu_div(cpu_div), .dbg_off(dbg_off), .sleep(sleep), .brownout(brownout),
    .cpu_en(cpu_en), .dbg_en(dbg_en), .ce_en(ce_en), .adc_en(adc_en)
  );

  assign outs = {dbg_en, cpu_en, ce_en, adc_en};

  int n_chk = 0, n_fail = 0, doubles = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: phases in integers, rates from the requirements.
  int  r_phase, r_plan, r_fast, r_tickcnt, r_div, r_per, r_span;
  int  r_bo[4];
  bit  r_out[4];
  bit  r_c[4];
  bit  r_tick, r_live = 0;
  bit  prev_out[4];
  string tags[4] = '{"R3", "R4", "R1", "R5"};

  always @(posedge clk) begin
    if (!rst_n) begin
      r_phase = 0; r_plan = 0; r_fast = 0; r_tickcnt = 0; r_div = 0;
      for (int i = 0; i < 4; i++) begin r_bo[i] = 0; r_out[i] = 0; end
    end else begin
      r_per  = (r_plan == 1) ? 3 : 4;
      r_span = 1 << (((r_div > 6) ? 6 : r_div) + 2);
      r_tick = (r_phase == r_per - 1);
      r_c[0] = r_tick;
      r_c[1] = r_tick || (r_plan == 2 && r_fast == 1 && r_phase == 1);
      r_c[2] = r_tick && (r_tickcnt == r_span - 1);
      r_c[3] = r_tick && (r_tickcnt == r_span - 1 || r_tickcnt == r_span / 2 - 1) && !dbg_off;
      for (int i = 0; i < 4; i++) begin
        r_out[i] = r_c[i] && !(brownout && r_bo[i] == 7);
        if (!brownout) r_bo[i] = 0;
        else if (r_c[i]) r_bo[i] = (r_bo[i] == 7) ? 0 : r_bo[i] + 1;
      end
      if (r_c[2]) r_div = cpu_div;
      if (r_tick) begin
        r_tickcnt = (r_tickcnt == r_span - 1) ? 0 : r_tickcnt + 1;
        r_phase = 0;
        r_fast  = ce_fast;
        if (sleep) r_plan = 0;
        else if (mode_sel == 2'b01) r_plan = 1;
        else if (mode_sel == 2'b10) r_plan = 2;
        else r_plan = 0;
      end else begin
        r_phase++;
      end
      r_live = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && r_live && !done) begin
      for (int i = 0; i < 4; i++) begin
        chk({tags[i], " model"}, int'(outs[i]), int'(r_out[i]));
        if (outs[i] && prev_out[i]) doubles++;
        prev_out[i] = outs[i];
      end
    end
  end

  task automatic window(int n, output int ca, output int ce, output int cp, output int cd);
    ca = 0; ce = 0; cp = 0; cd = 0;
    repeat (n) begin
      @(negedge clk);
      ca += int'(adc_en); ce += int'(ce_en); cp += int'(cpu_en); cd += int'(dbg_en);
    end
  endtask

  task automatic next_pulse(int sel, output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (!outs[sel] && k < 5000);
  endtask

  task automatic settle();
    repeat (2200) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int a, c, p, d, k;
    rst_n = 0; mode_sel = 2'b01; ce_fast = 0; cpu_div = 0;
    dbg_off = 0; sleep = 0; brownout = 0;
    repeat (3) @(negedge clk);
    chk("R2 outputs in reset", int'(outs), 0);
    rst_n = 1;
    next_pulse(0, k); chk("R2 first adc gap", k, 4);
    next_pulse(0, k); chk("R3 intermediate gap after latch", k, 3);

    mode_sel = 2'b00; settle();
    window(320, a, c, p, d);
    chk("R3 default adc", a, 80); chk("R4 default ce", c, 80);
    chk("R1 div0 cpu", p, 20);    chk("R5 div0 dbg", d, 40);

    cpu_div = 3; settle();
    window(1024, a, c, p, d);
    chk("R1 div3 cpu", p, 8); chk("R5 div3 dbg", d, 16);

    cpu_div = 7; settle();
    window(2048, a, c, p, d);
    chk("R1 div7 as div6 cpu", p, 2);

    next_pulse(2, k);
    cpu_div = 0;
    next_pulse(2, k); chk("R8 old divider period kept", k, 1024);
    next_pulse(2, k); chk("R8 new divider period", k, 16);

    mode_sel = 2'b01; settle();
    window(300, a, c, p, d);
    chk("R3 intermediate adc", a, 100); chk("R3 intermediate cpu", p, 25);
    chk("R3 intermediate ce", c, 100);

    mode_sel = 2'b10; ce_fast = 1; settle();
    window(320, a, c, p, d);
    chk("R4 fast ce", c, 160); chk("R4 adc stays", a, 80);
    ce_fast = 0; settle();
    window(320, a, c, p, d);
    chk("R4 high plan slow ce", c, 80);

    mode_sel = 2'b11; settle();
    window(320, a, c, p, d);
    chk("R3 reserved code adc", a, 80);

    mode_sel = 2'b01; sleep = 1; settle();
    window(320, a, c, p, d);
    chk("R6 sleep adc", a, 80); chk("R6 sleep cpu", p, 20);
    sleep = 0; mode_sel = 2'b00;

    dbg_off = 1; settle();
    window(320, a, c, p, d);
    chk("R5 dbg suppressed", d, 0); chk("R5 cpu unaffected", p, 20);
    dbg_off = 0;

    brownout = 1; settle();
    window(1280, a, c, p, d);
    chk("R7 brownout adc", a, 280); chk("R7 brownout ce", c, 280);
    chk("R7 brownout cpu", p, 70);  chk("R7 brownout dbg", d, 140);
    mode_sel = 2'b10; ce_fast = 1; settle();
    window(1280, a, c, p, d);
    chk("R7 brownout fast ce", c, 560);
    brownout = 0; ce_fast = 0; mode_sel = 2'b00; settle();

    next_pulse(0, k);
    mode_sel = 2'b01;
    next_pulse(0, k); chk("R8 old plan period kept", k, 4);
    next_pulse(0, k); chk("R8 new plan period", k, 3);

    chk("R9 no back-to-back strobes", doubles, 0);
    finish_run();
  end
endmodule